// File: doc/BRIEF.md
# Host/Device Circular Mailbox

This block is a shared mailbox between a host processor and an embedded controller. It holds two rings of 32-bit slots. The host pushes slots toward the device through a single-address transmit window, and the device pops them through its own receive window. The reverse ring works the same way with the roles swapped. Both sides use a plain 32-bit register port with one address bus, a write strobe, a read strobe, write data and registered read data.

Each side owns a control/status word. It packs the depth of the ring that side fills, that ring's 8-bit write and read pointers, an interrupt enable, a write-one-to-clear interrupt status, a self-clearing doorbell, a ready flag, a sticky drop flag and, on the host side, a reset request. Software finds the occupancy by subtracting the read pointer from the write pointer, modulo 256. Ringing the doorbell on one side raises the interrupt status of the other side. Each side drives an interrupt line from its own status and enable bits.

Register map, the same on both ports: address 0 is the side's own control word (read/write), address 1 is the transmit window (write pushes a slot), address 2 is the receive window (read pops a slot), and address 3 is a read-only view of the other side's control word.

Top module: `hd_mailbox`

## Requirements
- R1: A control word has this layout: [31:24] DEPTH, [23:16] write pointer, [15:8] read pointer, bit 5 drop flag, bit 4 reset request, bit 3 ready, bit 2 doorbell (always reads 0), bit 1 interrupt status, bit 0 interrupt enable, bits 7:6 zero. The host word describes the host-to-device ring and the device word describes the device-to-host ring. After reset both words read {DEPTH, 8'h00, 8'h00, 8'h00}.
- R2: A host write to address 1 stores the slot and adds 1 to the host-to-device write pointer. Device reads of address 2 return the stored slots in order and each adds 1 to the read pointer. Both pointers wrap modulo 256.
- R3: A device write to address 1 and host reads of address 2 behave the same way on the device-to-host ring. Read data appears on the read-data port in the cycle after the read strobe and holds until the next read. A read of address 1 returns zero.
- R4: The occupancy, write pointer minus read pointer modulo 256, never exceeds DEPTH. A window write into a full ring is dropped, leaves the write pointer unchanged and sets the writer's sticky drop flag (bit 5). Writing 1 to bit 5 clears the flag.
- R5: A receive-window read of an empty ring returns zero and leaves the read pointer unchanged.
- R6: Writing 1 to bit 1 of a side's own word clears its interrupt status. Writing 0 to bit 1 leaves it unchanged. When a set event arrives in the same cycle as the clear, the status stays set.
- R7: Writing 1 to the doorbell bit 2 of one side's word sets the other side's interrupt status.
- R8: Each side's ready bit 3 appears in its own word and in the other side's address-3 view. A ready change written by one side sets the other side's interrupt status.
- R9: Each interrupt output is high exactly when that side's interrupt status and interrupt enable are both set.
- R10: A host word write with bit 4 and bit 2 both set empties both rings (all pointers 0) and clears both ready bits and both drop flags. While bit 4 is written as 1, host ready stays 0. Bit 4 reads back in both words. Writing bit 4 as 0 with bit 2 set releases the request and rings the device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after the read |
| host_irq | output | 1 | Host interrupt |
| dev_addr | input | 2 | Device register address |
| dev_wr | input | 1 | Device write strobe |
| dev_rd | input | 1 | Device read strobe |
| dev_wdata | input | 32 | Device write data |
| dev_rdata | output | 32 | Device read data, valid the cycle after the read |
| dev_irq | output | 1 | Device interrupt |

## Verification
The bench fills a ring past its depth. A design with a wrong full test would overwrite the oldest slot or show an occupancy above DEPTH, and the drained data and the pointer fields would expose that. It reads an empty ring to catch a design that moves the read pointer or returns stale data. It runs 260 push/pop pairs to catch pointers that wrap at the ring depth instead of modulo 256. It clears the device status in the same cycle as a host doorbell, so a design that lets the clear win loses the event. It issues a reset request with data in both rings, which catches a design that empties only one ring, leaves a ready flag set or lets host ready return while the request is held.

// File: rtl/hd_mailbox_pkg.sv
package hd_mailbox_pkg;

  localparam int WORD_W = 32;
  localparam int PTR_W  = 8;
  localparam int CTL_W  = 6;

  // control-word bit positions (low byte)
  localparam int B_IE  = 0;
  localparam int B_IS  = 1;
  localparam int B_IG  = 2;
  localparam int B_RDY = 3;
  localparam int B_RST = 4;
  localparam int B_OVF = 5;

  typedef enum logic [1:0] {
    A_CSR   = 2'd0,
    A_TXWIN = 2'd1,
    A_RXWIN = 2'd2,
    A_PEER  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic ovf;
    logic rst;
    logic rdy;
    logic is;
    logic ie;
  } ctl_bits_t;

  function automatic logic [WORD_W-1:0] csr_word(
    input logic [PTR_W-1:0] depth,
    input logic [PTR_W-1:0] wp,
    input logic [PTR_W-1:0] rp,
    input ctl_bits_t        c
  );
    return {depth, wp, rp, 2'b00, c.ovf, c.rst, c.rdy, 1'b0, c.is, c.ie};
  endfunction

endpackage

// File: rtl/hd_mbx_ring.sv
module hd_mbx_ring
  import hd_mailbox_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic             drop
);

  localparam int IDX_W = $clog2(DEPTH);

  if (DEPTH < 2 || DEPTH > 128 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
    $error("hd_mbx_ring: DEPTH must be a power of two between 2 and 128");
  end

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q, occ;
  logic             full, empty, do_push, do_pop;

  assign occ     = wptr_q - rptr_q;
  assign full    = (occ == PTR_W'(DEPTH));
  assign empty   = (occ == '0);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign drop    = push & full & ~flush;
  assign wptr    = wptr_q;
  assign rptr    = rptr_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
    end
  end

  // storage: plain write port, no reset, so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q[IDX_W-1:0]] <= din;
  end

  // registered read port; an empty or flushed pop yields zero
  always_ff @(posedge clk) begin
    if (rst)      dout <= '0;
    else if (pop) dout <= do_pop ? mem[rptr_q[IDX_W-1:0]] : '0;
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    occ <= PTR_W'(DEPTH))
    else $error("occupancy above depth");

  p_full_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (push && full && !flush) |=> (wptr_q == $past(wptr_q)))
    else $error("write pointer moved on a full ring");

  p_empty_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !flush) |=> (rptr_q == $past(rptr_q)))
    else $error("read pointer moved on an empty ring");

  p_flush_empty_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (wptr_q == '0 && rptr_q == '0))
    else $error("flush left pointers non-zero");

endmodule

// File: rtl/hd_mbx_ctl.sv
module hd_mbx_ctl
  import hd_mailbox_pkg::*;
#(
  parameter bit HAS_RST = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wbits,
  input  logic             set_is,
  input  logic             clr,
  input  logic             ovf_set,
  output ctl_bits_t        bits_o,
  output logic             ring_o,
  output logic             rdy_chg_o,
  output logic             irq_o
);

  logic ie_q, is_q, rdy_q, ovf_q, rst_q;
  logic ie_d, is_d, rdy_d, ovf_d;

  always_comb begin
    ie_d = we ? wbits[B_IE] : ie_q;
    is_d = set_is | (is_q & ~(we & wbits[B_IS]));
    if (clr)     rdy_d = 1'b0;
    else if (we) rdy_d = wbits[B_RDY] & ~(logic'(HAS_RST) & wbits[B_RST]);
    else         rdy_d = rdy_q;
    if (clr) ovf_d = 1'b0;
    else     ovf_d = ovf_set | (ovf_q & ~(we & wbits[B_OVF]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q  <= 1'b0;
      is_q  <= 1'b0;
      rdy_q <= 1'b0;
      ovf_q <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      ie_q  <= ie_d;
      is_q  <= is_d;
      rdy_q <= rdy_d;
      ovf_q <= ovf_d;
      irq_o <= is_d & ie_d;
    end
  end

  if (HAS_RST) begin : g_rst
    always_ff @(posedge clk) begin
      if (rst)     rst_q <= 1'b0;
      else if (we) rst_q <= wbits[B_RST];
    end
  end else begin : g_norst
    assign rst_q = 1'b0;
  end

  assign ring_o    = we & wbits[B_IG];
  assign rdy_chg_o = we & ~clr & (rdy_d != rdy_q);
  assign bits_o    = '{ovf: ovf_q, rst: rst_q, rdy: rdy_q, is: is_q, ie: ie_q};

  p_set_is_r7: assert property (@(posedge clk) disable iff (rst)
    set_is |=> is_q)
    else $error("interrupt status not set by peer event");

  p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
    (we && wbits[B_IS] && !set_is) |=> !is_q)
    else $error("write-one-to-clear failed");

  p_irq_r9: assert property (@(posedge clk) disable iff (rst)
    irq_o == (is_q && ie_q))
    else $error("interrupt line disagrees with status and enable");

  p_clr_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!rdy_q && !ovf_q))
    else $error("reset request left ready or drop flag set");

endmodule

// File: rtl/hd_mbx_rdport.sv
module hd_mbx_rdport
  import hd_mailbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] own_csr,
  input  logic [WORD_W-1:0] peer_csr,
  input  logic [WORD_W-1:0] win_data,
  output logic [WORD_W-1:0] rdata
);

  reg_sel_e          sel_q;
  logic [WORD_W-1:0] csr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= A_CSR;
      csr_q <= '0;
    end else if (rd) begin
      sel_q <= reg_sel_e'(addr);
      case (reg_sel_e'(addr))
        A_CSR:   csr_q <= own_csr;
        A_PEER:  csr_q <= peer_csr;
        default: csr_q <= '0;
      endcase
    end
  end

  // the ring output is itself a register updated only by this side's pops
  assign rdata = (sel_q == A_RXWIN) ? win_data : csr_q;

  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (rdata == $past(rdata)))
    else $error("read data changed without a read");

endmodule

// File: rtl/hd_mailbox.sv
module hd_mailbox
  import hd_mailbox_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              host_irq,
  input  logic [1:0]        dev_addr,
  input  logic              dev_wr,
  input  logic              dev_rd,
  input  logic [WORD_W-1:0] dev_wdata,
  output logic [WORD_W-1:0] dev_rdata,
  output logic              dev_irq
);

  localparam logic [PTR_W-1:0] DEPTH_F = PTR_W'(DEPTH);

  logic h_csr_we, h_push, h_pop, d_csr_we, d_push, d_pop, flush;
  logic [PTR_W-1:0] h2d_wp, h2d_rp, d2h_wp, d2h_rp;
  logic [WORD_W-1:0] h2d_out, d2h_out, host_csr, dev_csr;
  logic h2d_drop, d2h_drop;
  logic h_ring, h_rchg, d_ring, d_rchg;
  ctl_bits_t h_bits, d_bits, d_view;

  assign h_csr_we = host_wr && (host_addr == A_CSR);
  assign h_push   = host_wr && (host_addr == A_TXWIN);
  assign h_pop    = host_rd && (host_addr == A_RXWIN);
  assign d_csr_we = dev_wr && (dev_addr == A_CSR);
  assign d_push   = dev_wr && (dev_addr == A_TXWIN);
  assign d_pop    = dev_rd && (dev_addr == A_RXWIN);

  // reset request: host writes reset together with the doorbell
  assign flush = h_csr_we & host_wdata[B_RST] & host_wdata[B_IG];

  hd_mbx_ring #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_h2d (
    .clk(clk), .rst(rst), .flush(flush),
    .push(h_push), .din(host_wdata), .pop(d_pop), .dout(h2d_out),
    .wptr(h2d_wp), .rptr(h2d_rp), .drop(h2d_drop)
  );

  hd_mbx_ring #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_d2h (
    .clk(clk), .rst(rst), .flush(flush),
    .push(d_push), .din(dev_wdata), .pop(h_pop), .dout(d2h_out),
    .wptr(d2h_wp), .rptr(d2h_rp), .drop(d2h_drop)
  );

  hd_mbx_ctl #(.HAS_RST(1'b1)) u_hctl (
    .clk(clk), .rst(rst), .we(h_csr_we), .wbits(host_wdata[CTL_W-1:0]),
    .set_is(d_ring | d_rchg), .clr(flush), .ovf_set(h2d_drop),
    .bits_o(h_bits), .ring_o(h_ring), .rdy_chg_o(h_rchg), .irq_o(host_irq)
  );

  hd_mbx_ctl #(.HAS_RST(1'b0)) u_dctl (
    .clk(clk), .rst(rst), .we(d_csr_we), .wbits(dev_wdata[CTL_W-1:0]),
    .set_is(h_ring | h_rchg), .clr(flush), .ovf_set(d2h_drop),
    .bits_o(d_bits), .ring_o(d_ring), .rdy_chg_o(d_rchg), .irq_o(dev_irq)
  );

  // the device sees the host reset request in its own word
  always_comb begin
    d_view     = d_bits;
    d_view.rst = h_bits.rst;
  end

  assign host_csr = csr_word(DEPTH_F, h2d_wp, h2d_rp, h_bits);
  assign dev_csr  = csr_word(DEPTH_F, d2h_wp, d2h_rp, d_view);

  hd_mbx_rdport u_hrd (
    .clk(clk), .rst(rst), .rd(host_rd), .addr(host_addr),
    .own_csr(host_csr), .peer_csr(dev_csr), .win_data(d2h_out), .rdata(host_rdata)
  );

  hd_mbx_rdport u_drd (
    .clk(clk), .rst(rst), .rd(dev_rd), .addr(dev_addr),
    .own_csr(dev_csr), .peer_csr(host_csr), .win_data(h2d_out), .rdata(dev_rdata)
  );

  p_doorbell_r7: assert property (@(posedge clk) disable iff (rst)
    (h_csr_we && host_wdata[B_IG]) |=> d_bits.is)
    else $error("host doorbell lost");

  p_hold_rdy_r10: assert property (@(posedge clk) disable iff (rst)
    h_bits.rst |-> !h_bits.rdy)
    else $error("host ready while reset request held");

endmodule

// File: tb/hd_mailbox_tb_top.sv
module hd_mailbox_tb_top;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  host_addr = '0, dev_addr = '0;
  logic        host_wr = 0, host_rd = 0, dev_wr = 0, dev_rd = 0;
  logic [31:0] host_wdata = '0, dev_wdata = '0;
  logic [31:0] host_rdata, dev_rdata;
  logic        host_irq, dev_irq;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  hd_mailbox #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
    .dev_addr(dev_addr), .dev_wr(dev_wr), .dev_rd(dev_rd),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_irq(dev_irq)
  );

  typedef struct packed {
    logic        dev;
    logic        rd;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 2'd0, 32'h0,  32'h04000000, 4'd1},  // R1 host word at reset
    '{1'b1, 1'b1, 2'd0, 32'h0,  32'h04000000, 4'd1},  // R1 device word at reset
    '{1'b0, 1'b0, 2'd1, 32'hA1, 32'h0,        4'd2},  // R2 push
    '{1'b0, 1'b0, 2'd1, 32'hA2, 32'h0,        4'd2},
    '{1'b0, 1'b1, 2'd0, 32'h0,  32'h04020000, 4'd2},
    '{1'b1, 1'b1, 2'd2, 32'h0,  32'h000000A1, 4'd2},  // R2 in order
    '{1'b0, 1'b1, 2'd0, 32'h0,  32'h04020100, 4'd2},
    '{1'b1, 1'b1, 2'd2, 32'h0,  32'h000000A2, 4'd2},
    '{1'b1, 1'b1, 2'd2, 32'h0,  32'h0,        4'd5},  // R5 empty read
    '{1'b0, 1'b1, 2'd0, 32'h0,  32'h04020200, 4'd5},  // R5 pointer held
    '{1'b1, 1'b0, 2'd1, 32'hB1, 32'h0,        4'd3},  // R3 device push
    '{1'b1, 1'b0, 2'd1, 32'hB2, 32'h0,        4'd3},
    '{1'b1, 1'b1, 2'd0, 32'h0,  32'h04020000, 4'd3},
    '{1'b0, 1'b1, 2'd2, 32'h0,  32'h000000B1, 4'd3},
    '{1'b0, 1'b1, 2'd2, 32'h0,  32'h000000B2, 4'd3},
    '{1'b1, 1'b1, 2'd0, 32'h0,  32'h04020200, 4'd3},
    '{1'b0, 1'b1, 2'd1, 32'h0,  32'h0,        4'd3},  // R3 tx window reads 0
    '{1'b0, 1'b0, 2'd0, 32'h4,  32'h0,        4'd7},  // R7 host doorbell
    '{1'b1, 1'b1, 2'd0, 32'h0,  32'h04020202, 4'd7},
    '{1'b0, 1'b1, 2'd0, 32'h0,  32'h04020200, 4'd7},  // R7 doorbell reads 0
    '{1'b1, 1'b0, 2'd0, 32'h1,  32'h0,        4'd6},  // R6 zero keeps status
    '{1'b1, 1'b1, 2'd0, 32'h0,  32'h04020203, 4'd6},
    '{1'b1, 1'b0, 2'd0, 32'h3,  32'h0,        4'd6},  // R6 one clears
    '{1'b1, 1'b1, 2'd0, 32'h0,  32'h04020201, 4'd6},
    '{1'b1, 1'b0, 2'd0, 32'h9,  32'h0,        4'd8},  // R8 device ready
    '{1'b0, 1'b1, 2'd0, 32'h0,  32'h04020202, 4'd8},
    '{1'b0, 1'b1, 2'd3, 32'h0,  32'h04020209, 4'd8},
    '{1'b0, 1'b0, 2'd0, 32'hF,  32'h0,        4'd8},  // R8 host ready
    '{1'b0, 1'b1, 2'd0, 32'h0,  32'h04020209, 4'd8},
    '{1'b1, 1'b1, 2'd3, 32'h0,  32'h04020209, 4'd8},
    '{1'b1, 1'b1, 2'd0, 32'h0,  32'h0402020B, 4'd8},
    '{1'b1, 1'b0, 2'd0, 32'h1,  32'h0,        4'd8},  // R8 ready drop
    '{1'b0, 1'b1, 2'd0, 32'h0,  32'h0402020B, 4'd8}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic h_acc(input logic rd, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_rd = rd; host_wr = ~rd; host_wdata = d;
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0;
  endtask

  task automatic d_acc(input logic rd, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    dev_addr = a; dev_rd = rd; dev_wr = ~rd; dev_wdata = d;
    @(negedge clk);
    dev_rd = 1'b0; dev_wr = 1'b0;
  endtask

  task automatic both_wr(input logic [31:0] hd, input logic [31:0] dd);
    @(negedge clk);
    host_addr = 2'd0; host_wr = 1'b1; host_wdata = hd;
    dev_addr  = 2'd0; dev_wr  = 1'b1; dev_wdata  = dd;
    @(negedge clk);
    host_wr = 1'b0; dev_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int mism;
    do_reset();
    check("R9 host irq at reset", {31'b0, host_irq}, 32'h0);
    check("R9 dev irq at reset", {31'b0, dev_irq}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].dev) d_acc(VEC[i].rd, VEC[i].addr, VEC[i].data);
      else            h_acc(VEC[i].rd, VEC[i].addr, VEC[i].data);
      if (VEC[i].rd)
        check($sformatf("R%0d vector %0d", VEC[i].req, i),
              VEC[i].dev ? dev_rdata : host_rdata, VEC[i].exp);
    end

    // R4: fill past depth
    do_reset();
    for (int i = 0; i < DEPTH + 1; i++) h_acc(1'b0, 2'd1, 32'h100 + i);
    h_acc(1'b1, 2'd0, '0);
    check("R4 full drop flag and pointer", host_rdata, 32'h04040020);
    for (int i = 0; i < DEPTH; i++) begin
      d_acc(1'b1, 2'd2, '0);
      check("R4 kept slots in order", dev_rdata, 32'h100 + i);
    end
    d_acc(1'b1, 2'd2, '0);
    check("R4 dropped slot absent", dev_rdata, 32'h0);
    h_acc(1'b1, 2'd0, '0);
    check("R4 drained pointers", host_rdata, 32'h04040420);
    h_acc(1'b0, 2'd0, 32'h20);
    h_acc(1'b1, 2'd0, '0);
    check("R4 drop flag cleared", host_rdata, 32'h04040400);

    // R9: interrupt lines
    do_reset();
    d_acc(1'b0, 2'd0, 32'h4);
    check("R9 status without enable", {31'b0, host_irq}, 32'h0);
    h_acc(1'b0, 2'd0, 32'h1);
    check("R9 status with enable", {31'b0, host_irq}, 32'h1);
    h_acc(1'b0, 2'd0, 32'h3);
    check("R9 cleared status", {31'b0, host_irq}, 32'h0);
    h_acc(1'b0, 2'd0, 32'h5);
    check("R9 dev status without enable", {31'b0, dev_irq}, 32'h0);
    d_acc(1'b0, 2'd0, 32'h1);
    check("R9 dev status with enable", {31'b0, dev_irq}, 32'h1);

    // R6: set in the same cycle as clear
    both_wr(32'h5, 32'h3);
    d_acc(1'b1, 2'd0, '0);
    check("R6 set wins over clear", dev_rdata, 32'h04000003);
    d_acc(1'b0, 2'd0, 32'h3);
    d_acc(1'b1, 2'd0, '0);
    check("R6 clear alone", dev_rdata, 32'h04000001);

    // R10: reset request and release
    do_reset();
    h_acc(1'b0, 2'd1, 32'h11);
    d_acc(1'b0, 2'd1, 32'h22);
    d_acc(1'b0, 2'd0, 32'h8);
    h_acc(1'b0, 2'd0, 32'h8);
    h_acc(1'b0, 2'd0, 32'h1C);
    h_acc(1'b1, 2'd0, '0);
    check("R10 host word after request", host_rdata, 32'h04000012);
    d_acc(1'b1, 2'd0, '0);
    check("R10 device word after request", dev_rdata, 32'h04000012);
    h_acc(1'b1, 2'd2, '0);
    check("R10 device ring emptied", host_rdata, 32'h0);
    d_acc(1'b1, 2'd2, '0);
    check("R10 host ring emptied", dev_rdata, 32'h0);
    h_acc(1'b0, 2'd0, 32'h18);
    h_acc(1'b1, 2'd0, '0);
    check("R10 host ready held low", host_rdata, 32'h04000012);
    h_acc(1'b0, 2'd0, 32'h4);
    h_acc(1'b1, 2'd0, '0);
    check("R10 host word after release", host_rdata, 32'h04000002);
    d_acc(1'b1, 2'd0, '0);
    check("R10 device word after release", dev_rdata, 32'h04000002);

    // R2: pointer wrap modulo 256
    do_reset();
    mism = 0;
    for (int i = 0; i < 260; i++) begin
      h_acc(1'b0, 2'd1, 32'(i));
      d_acc(1'b1, 2'd2, '0);
      if (dev_rdata !== 32'(i)) mism++;
    end
    check("R2 data across wrap", 32'(mism), 32'h0);
    h_acc(1'b1, 2'd0, '0);
    check("R2 pointers wrap modulo 256", host_rdata, 32'h04040400);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule